// File: doc/BRIEF.md
# General-Purpose Timer Channel

A single counter channel with three run modes. In the two timer modes it loads a start value, counts down once per clock and raises a one-cycle event when the count passes through zero. One-shot stops at that point. Periodic reloads and keeps going. In capture mode the counter runs freely downward. A chosen transition on an external pin copies the running count into a capture register and raises the same event output.

A control write sets the enable, the mode, the capture edge selection, a freeze-while-halted option and an output inversion. Only the enable can change while the channel runs. While the enable is set, a write leaves the other fields as they were. A level output is high while the count is in the lower half of the start value. This output can be inverted.

Top module: `gp_timer_channel`

## Requirements
- R1: After reset the enable, mode, edge, freeze and invert fields are 0. The count and the capture value are 0, the event output is 0 and the level output is 0.
- R2: A control write with enable 1 while the channel is disabled starts it. For mode code 1 (one-shot) or 2 (periodic) the count loads the start value on that clock edge. It then falls by one on each counting clock. The clock edge on which the count is 0 sets the event output high for exactly the following cycle.
- R3: In one-shot mode, the timeout stops counting. The count stays at 0 and no further events occur until the channel is restarted.
- R4: In periodic mode, the timeout reloads the start value and counting continues, so events are spaced by start value plus one cycles.
- R5: Mode code 0 leaves the channel idle even when enabled. The count holds and no event occurs.
- R6: Mode code 3 starts a free-running down-count from all ones. The pin passes through two synchroniser flops. A qualifying edge latches the count into the capture value and pulses the event output, three clock edges after the pin changes. The edge code selects the edge: 0 = rising, 1 = falling, 3 = both, 2 = none.
- R7: While the freeze bit is 1 and debug-halt is high, the count holds. With the freeze bit 0, debug-halt has no effect. With debug-halt low, the freeze bit has no effect.
- R8: While the enable is 0 the count holds and no event occurs. A write with enable 0 disables the channel.
- R9: The level output is (enabled AND mode 1 or 2 AND count <= start value / 2), XOR the invert bit.
- R10: While the channel is enabled, a control write changes only the enable. The mode, edge, freeze and invert fields keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_halt | input | 1 | Processor held halted by a debugger |
| cap_pin | input | 1 | Asynchronous capture pin |
| load_val | input | W | Start and reload value |
| ctl_we | input | 1 | Control write strobe |
| ctl_en | input | 1 | Enable value to write |
| ctl_mode | input | 2 | Mode code to write |
| ctl_edge | input | 2 | Capture edge code to write |
| ctl_freeze | input | 1 | Freeze-on-halt value to write |
| ctl_invert | input | 1 | Output inversion value to write |
| count | output | W | Current count |
| cap_val | output | W | Last captured count |
| evt | output | 1 | One-cycle timeout or capture event |
| lvl_out | output | 1 | Level output after optional inversion |

## Verification
Two functions can act in the same cycle: a capture edge and a debug-halt freeze. The bench raises debug-halt at the same moment it moves the capture pin, with freeze enabled. It then expects the captured value to equal the held count, not that count minus two. A second overlap pairs a locked control write with a live periodic count. Debug-halt is raised right after a write that attempts to set freeze. The count must keep its periodic wrap on every cycle, and the level output must keep its old polarity.

// File: rtl/gp_timer_channel.sv
module gp_timer_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dbg_halt,
  input  logic         cap_pin,
  input  logic [W-1:0] load_val,
  input  logic         ctl_we,
  input  logic         ctl_en,
  input  logic [1:0]   ctl_mode,
  input  logic [1:0]   ctl_edge,
  input  logic         ctl_freeze,
  input  logic         ctl_invert,
  output logic [W-1:0] count,
  output logic [W-1:0] cap_val,
  output logic         evt,
  output logic         lvl_out
);
  localparam logic [1:0] M_ONE = 2'd1;
  localparam logic [1:0] M_PER = 2'd2;
  localparam logic [1:0] M_CAP = 2'd3;
  localparam logic [W-1:0] ONE = W'(1);

  logic         en_q, frz_q, inv_q, run_q, evt_q;
  logic [1:0]   mode_q, edge_q;
  logic [W-1:0] cnt_q, cap_q;
  logic         s1, s2, s3;

  wire tick   = en_q && !(frz_q && dbg_halt);
  wire start  = ctl_we && ctl_en && !en_q;
  wire timer  = (mode_q == M_ONE) || (mode_q == M_PER);
  wire rise   = s2 && !s3;
  wire fall   = !s2 && s3;
  wire hit    = (edge_q == 2'd0) ? rise :
                (edge_q == 2'd1) ? fall :
                (edge_q == 2'd3) ? (rise || fall) : 1'b0;
  wire raw    = en_q && timer && (cnt_q <= (load_val >> 1));

  assign count   = cnt_q;
  assign cap_val = cap_q;
  assign evt     = evt_q;
  assign lvl_out = raw ^ inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s1, s2, s3} <= 3'b000;
    end else begin
      s1 <= cap_pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 2'd0;
      edge_q <= 2'd0;
      frz_q  <= 1'b0;
      inv_q  <= 1'b0;
      run_q  <= 1'b0;
      evt_q  <= 1'b0;
      cnt_q  <= '0;
      cap_q  <= '0;
    end else begin
      evt_q <= 1'b0;
      if (ctl_we) begin
        en_q <= ctl_en;
        if (!en_q) begin
          mode_q <= ctl_mode;
          edge_q <= ctl_edge;
          frz_q  <= ctl_freeze;
          inv_q  <= ctl_invert;
        end
      end
      if (start) begin
        case (ctl_mode)
          M_ONE, M_PER: begin cnt_q <= load_val; run_q <= 1'b1; end
          M_CAP:        begin cnt_q <= '1;       run_q <= 1'b0; end
          default:      run_q <= 1'b0;
        endcase
      end else if (tick) begin
        if (timer && run_q) begin
          if (cnt_q == '0) begin
            evt_q <= 1'b1;
            if (mode_q == M_PER) cnt_q <= load_val;
            else                 run_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end else if (mode_q == M_CAP) begin
          cnt_q <= cnt_q - ONE;
        end
      end
      if (en_q && mode_q == M_CAP && hit) begin
        cap_q <= cnt_q;
        evt_q <= 1'b1;
      end
      if (ctl_we && !ctl_en) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/gp_timer_channel_chk.sv
module gp_timer_channel_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dbg_halt,
  input logic         en_q,
  input logic [1:0]   mode_q,
  input logic [1:0]   edge_q,
  input logic         frz_q,
  input logic         inv_q,
  input logic         run_q,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cap,
  input logic         evt
);
  localparam logic [W-1:0] ONE = W'(1);

  a_r8_idle_no_evt: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !evt);

  a_r7_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && frz_q && dbg_halt) |=> $stable(cnt));

  a_r5_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mode_q == 2'd0) |=> ($stable(cnt) && !evt));

  a_r3_oneshot_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mode_q == 2'd1 && !run_q) |=> ($stable(cnt) && !evt));

  a_r10_fields_locked: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> ($stable(mode_q) && $stable(edge_q) && $stable(frz_q) && $stable(inv_q)));

  a_r6_cap_only_in_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q || mode_q != 2'd3) |=> $stable(cap));

  a_r2_down_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && run_q && !(frz_q && dbg_halt) && cnt != '0) |=> (cnt == $past(cnt) - ONE));
endmodule

bind gp_timer_channel gp_timer_channel_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt), .en_q(en_q), .mode_q(mode_q),
  .edge_q(edge_q), .frz_q(frz_q), .inv_q(inv_q), .run_q(run_q),
  .cnt(cnt_q), .cap(cap_q), .evt(evt_q)
);

// File: tb/test_gp_timer_channel.sv
`timescale 1ns/1ps
module test_gp_timer_channel;
  localparam int W = 16;
  logic clk = 0, rst_n = 0, dbg_halt = 0, cap_pin = 0;
  logic [W-1:0] load_val = '0;
  logic ctl_we = 0, ctl_en = 0, ctl_freeze = 0, ctl_invert = 0;
  logic [1:0] ctl_mode = 0, ctl_edge = 0;
  logic [W-1:0] count, cap_val;
  logic evt, lvl_out;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  gp_timer_channel #(.W(W)) i_gp_timer_channel (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit en, input logic [1:0] m, input logic [1:0] e, input bit f, input bit inv);
    @(negedge clk);
    ctl_we = 1; ctl_en = en; ctl_mode = m; ctl_edge = e; ctl_freeze = f; ctl_invert = inv;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic cap_trial(input logic [1:0] code, input bit to_high);
    logic [W-1:0] c0, prev;
    bit sel;
    sel = (code == 2'd3) || (code == 2'd0 && to_high) || (code == 2'd1 && !to_high);
    repeat (2) @(negedge clk);
    c0 = count; prev = cap_val;
    cap_pin = to_high;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk(evt == (sel && k == 3), "R6 capture event", evt, sel && k == 3);
      if (k == 3)
        chk(cap_val == (sel ? c0 - W'(2) : prev), "R6 captured value", cap_val, sel ? c0 - W'(2) : prev);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] c, p;
    int nevt;
    repeat (3) @(negedge clk);
    chk(count == 0, "R1 count", count, 0);
    chk(cap_val == 0, "R1 cap", cap_val, 0);
    chk(evt == 0, "R1 evt", evt, 0);
    chk(lvl_out == 0, "R1 level", lvl_out, 0);
    rst_n = 1;
    @(negedge clk);
    chk(count == 0, "R1 count after release", count, 0);

    // timer sweep: R2, R3, R4, R9
    for (int m = 1; m <= 2; m++)
      for (int inv = 0; inv <= 1; inv++)
        for (int L = 0; L <= 7; L++) begin
          load_val = W'(L);
          wr(0, 0, 0, 0, 0);
          wr(1, 2'(m), 0, L[0], inv[0]);
          for (int n = 0; n <= 2 * L + 4; n++) begin
            int ec; bit ee;
            if (m == 2) begin
              ec = L - (n % (L + 1));
              ee = (n > 0) && (n % (L + 1) == 0);
            end else begin
              ec = (n >= L) ? 0 : L - n;
              ee = (n == L + 1);
            end
            chk(count == W'(ec), m == 2 ? "R4 periodic count" : "R3 one-shot count", count, ec);
            chk(evt == ee, m == 2 ? "R4 periodic event" : "R2 R3 timeout event", evt, ee);
            chk(lvl_out == ((ec <= L / 2) ^ inv[0]), "R9 level", lvl_out, (ec <= L / 2) ^ inv[0]);
            @(negedge clk);
          end
        end

    // R8 disable holds
    load_val = 16'd40;
    wr(0, 0, 0, 0, 0);
    wr(1, 2, 0, 0, 0);
    repeat (5) @(negedge clk);
    wr(0, 0, 0, 0, 0);
    c = count;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(count == c && !evt, "R8 disabled idle", count, c);
    end
    chk(lvl_out == 0, "R8 R9 level when disabled", lvl_out, 0);

    // R5 reserved mode
    wr(1, 0, 0, 0, 1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(count == c && !evt, "R5 reserved mode idle", count, c);
      chk(lvl_out == 1, "R5 R9 level inverted idle", lvl_out, 1);
    end

    // R7 freeze during halt
    load_val = 16'd200;
    wr(0, 0, 0, 0, 0);
    wr(1, 2, 0, 1, 0);
    @(negedge clk);
    c = count; dbg_halt = 1;
    repeat (5) @(negedge clk);
    chk(count == c, "R7 frozen while halted", count, c);
    dbg_halt = 0;
    @(negedge clk);
    chk(count == c - 1, "R7 resumes after halt", count, c - 1);
    wr(0, 0, 0, 0, 0);
    wr(1, 2, 0, 0, 0);
    @(negedge clk);
    c = count; dbg_halt = 1;
    repeat (5) @(negedge clk);
    chk(count == c - 5, "R7 no freeze when bit clear", count, c - 5);
    dbg_halt = 0;

    // R10 locked write during periodic run
    load_val = 16'd5;
    wr(0, 0, 0, 0, 0);
    wr(1, 2, 0, 0, 0);
    @(negedge clk);
    wr(1, 1, 3, 1, 1);
    dbg_halt = 1;
    p = count; nevt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(count == ((p == 0) ? 16'd5 : p - 1), "R10 R7 periodic unaffected", count, (p == 0) ? 5 : p - 1);
      chk(lvl_out == (count <= 2), "R10 invert unchanged", lvl_out, count <= 2);
      if (evt) nevt++;
      p = count;
    end
    chk(nevt >= 3, "R10 mode still periodic", nevt, 3);
    dbg_halt = 0;

    // R6 capture with each edge code
    for (int code = 0; code <= 3; code++) begin
      wr(0, 0, 0, 0, 0);
      wr(1, 3, 2'(code), 0, 0);
      chk(count == 16'hFFFF, "R6 free-run start", count, 16'hFFFF);
      cap_trial(2'(code), 1);
      cap_trial(2'(code), 0);
    end

    // capture coinciding with freeze
    wr(0, 0, 0, 0, 0);
    wr(1, 3, 0, 1, 0);
    repeat (3) @(negedge clk);
    c = count; dbg_halt = 1; cap_pin = 1;
    repeat (3) @(negedge clk);
    chk(evt == 1, "R6 R7 capture while frozen event", evt, 1);
    chk(cap_val == c, "R6 R7 capture while frozen value", cap_val, c);
    chk(count == c, "R7 count held in capture", count, c);
    dbg_halt = 0; cap_pin = 0;
    repeat (4) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule